// File: doc/BRIEF.md
# Mobile SDRAM Global Command State Monitor

This block sits beside the command bus of a multi-bank low-power SDRAM and tracks the device's global operating state. It samples the active-low chip-select, row-strobe, column-strobe and write-enable lines on every rising clock edge and decodes them into a command. A bank-select-all qualifier is also sampled, because it is the address bit that turns a precharge into a precharge-all. From these commands the block moves between five states: all banks idle, precharging all, refreshing, mode-register access and deep power-down.

The three timed states each last for a cycle budget set by a parameter: a recovery time after precharge-all, a refresh cycle time, and a mode-register settle time. During a timed state the bus may carry only no-operation or deselect. The encoding that ordinary SDRAM uses for burst stop is taken here as a request to enter deep power-down. Deep power-down is left only when a dedicated exit input is asserted.

Global commands need every bank closed, so the per-bank open flags are an input. Any rule break produces a one-cycle error pulse with a code that names the class of fault. The block observes the bus and never drives it.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `monState` is 0 (all idle), `errPulse` is 0 and `errCode` is 0.
- R2: Commands are decoded from {csN,rasN,casN,weN}. csN=1 is deselect. {rasN,casN,weN}=111 is no-operation, 011 is activate, 101 is read, 100 is write, 110 is deep power-down entry, 010 is precharge (precharge-all when `allBanks`=1), 001 is auto refresh and 000 is mode-register load. Deselect and no-operation in the idle state raise no error and change no state.
- R3: Precharge-all registered in the idle state sets `monState` to 1 for exactly T_RP-1 cycles and then returns it to 0, whatever the bank open flags are.
- R4: Auto refresh registered in the idle state with no bank open sets `monState` to 2 for exactly T_RC-1 cycles, then returns it to 0.
- R5: Mode-register load registered in the idle state with no bank open sets `monState` to 3 for exactly T_MRD-1 cycles, then returns it to 0.
- R6: In states 1, 2 or 3, any command other than deselect or no-operation produces an error pulse with `errCode`=1 in the next cycle. It does not change the duration of the timed state.
- R7: Auto refresh, mode-register load or deep power-down entry while any `bankOpen` bit is set produces `errCode`=2 and leaves `monState` at 0.
- R8: The 110 encoding with all banks closed sets `monState` to 4. The state holds there for as long as `dpdExit` stays low.
- R9: In state 4, any command other than deselect or no-operation produces `errCode`=3 and `monState` stays at 4.
- R10: `dpdExit` in state 4 returns `monState` to 0 with no error. `dpdExit` in any other state produces `errCode`=3, unless a command fault of code 1 or 2 is raised in the same cycle, in which case that code is reported.
- R11: Activate, read, write and single-bank precharge in the idle state produce no error and leave `monState` at 0, whatever the bank open flags are.
- R12: `errPulse` is high for exactly one cycle per offending edge. `errCode` is nonzero exactly when `errPulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| allBanks | input | 1 | Precharge targets all banks when high |
| bankOpen | input | NUM_BANKS | One flag per bank, high while that bank has a row open |
| dpdExit | input | 1 | Exit condition for deep power-down |
| monState | output | 3 | 0 idle, 1 precharging all, 2 refreshing, 3 mode access, 4 deep power-down |
| errPulse | output | 1 | One-cycle error strobe |
| errCode | output | 2 | 0 none, 1 timed state interrupted, 2 bank not idle, 3 illegal sequence |

## Verification
On every cycle, the embedded properties check the following:
- a disallowed command in a timed state yields code 1 in the next cycle;
- a blocked global command yields code 2 and the block stays idle;
- deep power-down holds until its exit input and then leaves;
- the shared timer never leaves its range;
- the error code and the pulse agree.

Other behaviours can only be shown by the bench's scenarios: the exact length of each timed state, the full cross of every command code with each state, bank pattern and exit level, and the priority between a command fault and a stray exit.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PRE_ALL  = 3'd1,
    ST_REFRESH  = 3'd2,
    ST_MODE_REG = 3'd3,
    ST_DEEP_PD  = 3'd4
  } mon_state_e;

  typedef enum logic [3:0] {
    CMD_DESELECT,
    CMD_NOP,
    CMD_ACTIVATE,
    CMD_READ,
    CMD_WRITE,
    CMD_DPD_ENTER,
    CMD_PRE_ONE,
    CMD_PRE_ALL,
    CMD_REFRESH,
    CMD_LOAD_MODE
  } mon_cmd_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_INTERRUPT = 2'd1,
    ERR_BANK_BUSY = 2'd2,
    ERR_ILLEGAL   = 2'd3
  } mon_err_e;

  typedef enum logic [1:0] {
    TSEL_RP,
    TSEL_RC,
    TSEL_MRD
  } timer_sel_e;

  typedef struct packed {
    logic       loadEn;
    timer_sel_e loadSel;
    logic       decEn;
  } ctrl_strobe_t;

endpackage

// File: rtl/sdram_mon_datapath.sv
module sdram_mon_datapath
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 allBanks,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  ctrl_strobe_t         strobe,
  output mon_cmd_e             cmd,
  output logic                 anyOpen,
  output logic                 cntZero
);

  // Timed states span T-1 cycles, so the counter is loaded with T-2.
  localparam int LOAD_RP_I  = (T_RP  > 2) ? T_RP  - 2 : 0;
  localparam int LOAD_RC_I  = (T_RC  > 2) ? T_RC  - 2 : 0;
  localparam int LOAD_MRD_I = (T_MRD > 2) ? T_MRD - 2 : 0;
  localparam int MAX_LOAD   = (LOAD_RP_I > LOAD_RC_I)
                            ? ((LOAD_RP_I > LOAD_MRD_I) ? LOAD_RP_I : LOAD_MRD_I)
                            : ((LOAD_RC_I > LOAD_MRD_I) ? LOAD_RC_I : LOAD_MRD_I);
  localparam int CNT_W      = (MAX_LOAD < 1) ? 1 : $clog2(MAX_LOAD + 1);

  localparam logic [CNT_W-1:0] LOAD_RP  = CNT_W'(LOAD_RP_I);
  localparam logic [CNT_W-1:0] LOAD_RC  = CNT_W'(LOAD_RC_I);
  localparam logic [CNT_W-1:0] LOAD_MRD = CNT_W'(LOAD_MRD_I);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] loadVal;

  // Command decode
  always_comb begin
    if (csN) begin
      cmd = CMD_DESELECT;
    end else begin
      unique case ({rasN, casN, weN})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACTIVATE;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b110:  cmd = CMD_DPD_ENTER;
        3'b010:  cmd = allBanks ? CMD_PRE_ALL : CMD_PRE_ONE;
        3'b001:  cmd = CMD_REFRESH;
        default: cmd = CMD_LOAD_MODE;
      endcase
    end
  end

  assign anyOpen = |bankOpen;

  always_comb begin
    unique case (strobe.loadSel)
      TSEL_RC:  loadVal = LOAD_RC;
      TSEL_MRD: loadVal = LOAD_MRD;
      default:  loadVal = LOAD_RP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.loadEn) begin
      cntQ <= loadVal;
    end else if (strobe.decEn && (cntQ != '0)) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign cntZero = (cntQ == '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(cntQ) <= MAX_LOAD) else $error("timer out of range"); // R3

  AST_DEC_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decEn && !strobe.loadEn && !cntZero) |=> (cntQ == $past(cntQ) - 1'b1))
    else $error("timer did not step"); // R4

endmodule

// File: rtl/sdram_mon_ctrl.sv
module sdram_mon_ctrl
  import sdram_mon_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  mon_cmd_e     cmd,
  input  logic         anyOpen,
  input  logic         cntZero,
  input  logic         dpdExit,
  output ctrl_strobe_t strobe,
  output mon_state_e   state,
  output logic         errPulse,
  output mon_err_e     errCode
);

  mon_state_e nextState;
  mon_err_e   errNow;
  logic       isQuiet;
  logic       isTimed;

  assign isQuiet = (cmd == CMD_DESELECT) || (cmd == CMD_NOP);
  assign isTimed = (state == ST_PRE_ALL) || (state == ST_REFRESH) ||
                   (state == ST_MODE_REG);

  always_comb begin
    nextState = state;
    errNow    = ERR_NONE;
    strobe    = '{loadEn: 1'b0, loadSel: TSEL_RP, decEn: 1'b0};
    unique case (state)
      ST_IDLE: begin
        unique case (cmd)
          CMD_PRE_ALL: begin
            nextState      = ST_PRE_ALL;
            strobe.loadEn  = 1'b1;
            strobe.loadSel = TSEL_RP;
          end
          CMD_REFRESH: begin
            if (anyOpen) begin
              errNow = ERR_BANK_BUSY;
            end else begin
              nextState      = ST_REFRESH;
              strobe.loadEn  = 1'b1;
              strobe.loadSel = TSEL_RC;
            end
          end
          CMD_LOAD_MODE: begin
            if (anyOpen) begin
              errNow = ERR_BANK_BUSY;
            end else begin
              nextState      = ST_MODE_REG;
              strobe.loadEn  = 1'b1;
              strobe.loadSel = TSEL_MRD;
            end
          end
          CMD_DPD_ENTER: begin
            if (anyOpen) errNow = ERR_BANK_BUSY;
            else         nextState = ST_DEEP_PD;
          end
          default: ;
        endcase
      end
      ST_PRE_ALL, ST_REFRESH, ST_MODE_REG: begin
        if (!isQuiet) errNow = ERR_INTERRUPT;
        if (cntZero) nextState = ST_IDLE;
        else         strobe.decEn = 1'b1;
      end
      ST_DEEP_PD: begin
        if (!isQuiet) errNow = ERR_ILLEGAL;
        if (dpdExit)  nextState = ST_IDLE;
      end
      default: begin
        nextState = ST_IDLE;
        errNow    = ERR_ILLEGAL;
      end
    endcase
    if ((errNow == ERR_NONE) && dpdExit && (state != ST_DEEP_PD)) begin
      errNow = ERR_ILLEGAL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      errPulse <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      state    <= nextState;
      errPulse <= (errNow != ERR_NONE);
      errCode  <= errNow;
    end
  end

  AST_TIMED_INTERRUPT: assert property (@(posedge clk) disable iff (!rstN)
    (isTimed && !isQuiet) |=> (errPulse && errCode == ERR_INTERRUPT))
    else $error("interrupt not flagged"); // R6

  AST_TIMED_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (isTimed && cntZero) |=> (state == ST_IDLE))
    else $error("timed state overran"); // R3

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && anyOpen &&
     (cmd == CMD_REFRESH || cmd == CMD_LOAD_MODE || cmd == CMD_DPD_ENTER))
    |=> (state == ST_IDLE && errCode == ERR_BANK_BUSY))
    else $error("global command with open bank"); // R7

  AST_DPD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEEP_PD && !dpdExit) |=> (state == ST_DEEP_PD))
    else $error("left deep power-down early"); // R8

  AST_DPD_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEEP_PD && dpdExit) |=> (state == ST_IDLE))
    else $error("exit ignored"); // R10

  AST_BANK_CMD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !dpdExit &&
     (cmd == CMD_ACTIVATE || cmd == CMD_READ || cmd == CMD_WRITE || cmd == CMD_PRE_ONE))
    |=> (!errPulse && state == ST_IDLE))
    else $error("bank command disturbed state"); // R11

  AST_CODE_MATCHES_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse == (errCode != ERR_NONE))
    else $error("code and pulse disagree"); // R12

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 allBanks,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 dpdExit,
  output logic [2:0]           monState,
  output logic                 errPulse,
  output logic [1:0]           errCode
);

  ctrl_strobe_t strobe;
  mon_cmd_e     cmd;
  logic         anyOpen;
  logic         cntZero;
  mon_state_e   state;
  mon_err_e     errCodeE;

  sdram_mon_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .T_RP      (T_RP),
    .T_RC      (T_RC),
    .T_MRD     (T_MRD)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .allBanks (allBanks),
    .bankOpen (bankOpen),
    .strobe   (strobe),
    .cmd      (cmd),
    .anyOpen  (anyOpen),
    .cntZero  (cntZero)
  );

  sdram_mon_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .anyOpen  (anyOpen),
    .cntZero  (cntZero),
    .dpdExit  (dpdExit),
    .strobe   (strobe),
    .state    (state),
    .errPulse (errPulse),
    .errCode  (errCodeE)
  );

  assign monState = state;
  assign errCode  = errCodeE;

endmodule

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;
  localparam int NB   = 4;
  localparam int TRP  = 3;
  localparam int TRC  = 5;
  localparam int TMRD = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic allBanks = 1'b0, dpdExit = 1'b0;
  logic [NB-1:0] bankOpen = '0;
  logic [2:0] monState;
  logic errPulse;
  logic [1:0] errCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(.NUM_BANKS(NB), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .allBanks(allBanks), .bankOpen(bankOpen), .dpdExit(dpdExit),
    .monState(monState), .errPulse(errPulse), .errCode(errCode)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycle(bit cs, bit [2:0] rcw, bit all, logic [NB-1:0] banks, bit ex);
    @(negedge clk);
    csN = cs; {rasN, casN, weN} = rcw; allBanks = all; bankOpen = banks; dpdExit = ex;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; csN = 1'b1; {rasN, casN, weN} = 3'b111;
    allBanks = 1'b0; bankOpen = '0; dpdExit = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic int timedLen(int st);
    return (st == 1) ? TRP : (st == 2) ? TRC : TMRD;
  endfunction

  // Count how many cycles a freshly entered timed state shows on monState.
  task automatic measure(string req, bit [2:0] rcw, bit all, logic [NB-1:0] banks, int st);
    int len;
    doReset();
    cycle(1'b0, rcw, all, banks, 1'b0);
    len = 0;
    for (int i = 0; i < 40; i++) begin
      if (monState != 3'(st)) break;
      len++;
      cycle(1'b0, 3'b111, 1'b0, banks, 1'b0);
    end
    check(req, len, timedLen(st) - 1);
    check(req, monState, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int expState, expErr;
    bit isNop;
    string tag;
    logic [NB-1:0] pat;

    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1", monState, 0);
    check("R1", errPulse, 0);
    check("R1", errCode, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", monState, 0);
    check("R1", errPulse, 0);

    // R3/R4/R5: timed state durations (precharge-all with banks open)
    measure("R3", 3'b010, 1'b1, 4'b1011, 1);
    measure("R4", 3'b001, 1'b0, '0, 2);
    measure("R5", 3'b000, 1'b0, '0, 3);

    // R8: deep power-down holds for many cycles without exit
    doReset();
    cycle(1'b0, 3'b110, 1'b0, '0, 1'b0);
    check("R8", monState, 4);
    for (int i = 0; i < 20; i++) cycle(i[0], 3'b111, 1'b0, '0, 1'b0);
    check("R8", monState, 4);
    check("R8", errPulse, 0);
    cycle(1'b1, 3'b111, 1'b0, '0, 1'b1);
    check("R10", monState, 0);
    check("R10", errPulse, 0);

    // R12: error pulse lasts one cycle
    doReset();
    cycle(1'b0, 3'b001, 1'b0, 4'b0100, 1'b0);
    check("R12", errPulse, 1);
    check("R7", errCode, 2);
    cycle(1'b0, 3'b111, 1'b0, 4'b0100, 1'b0);
    check("R12", errPulse, 0);
    check("R12", errCode, 0);

    // Sweep: every starting state x command x select x bank pattern x exit
    for (int st = 0; st < 5; st++)
      for (int cs = 0; cs < 2; cs++)
        for (int rcw = 0; rcw < 8; rcw++)
          for (int all = 0; all < 2; all++)
            for (int op = 0; op < 2; op++)
              for (int ex = 0; ex < 2; ex++) begin
                pat = op ? 4'b0010 : 4'b0000;
                doReset();
                case (st)
                  1: cycle(1'b0, 3'b010, 1'b1, '0, 1'b0);
                  2: cycle(1'b0, 3'b001, 1'b0, '0, 1'b0);
                  3: cycle(1'b0, 3'b000, 1'b0, '0, 1'b0);
                  4: cycle(1'b0, 3'b110, 1'b0, '0, 1'b0);
                  default: ;
                endcase
                check(st == 4 ? "R8" : st == 3 ? "R5" : st == 2 ? "R4" : st == 1 ? "R3" : "R1",
                      monState, st);
                cycle(cs[0], rcw[2:0], all[0], pat, ex[0]);
                isNop = (cs != 0) || (rcw == 7);
                if (st == 0) begin
                  expState = 0;
                  expErr   = ex ? 3 : 0;
                  if (!isNop) begin
                    case (rcw)
                      3'b010: expState = all ? 1 : 0;
                      3'b001, 3'b000, 3'b110: begin
                        if (op) expErr = 2;
                        else expState = (rcw == 1) ? 2 : (rcw == 0) ? 3 : 4;
                      end
                      default: ;
                    endcase
                  end
                end else if (st == 4) begin
                  expErr   = isNop ? 0 : 3;
                  expState = ex ? 0 : 4;
                end else begin
                  expErr   = !isNop ? 1 : (ex ? 3 : 0);
                  expState = (timedLen(st) >= 3) ? st : 0;
                end
                if (expErr == 1) tag = "R6";
                else if (expErr == 2) tag = "R7";
                else if (expErr == 3) tag = (st == 4) ? "R9" : "R10";
                else if (st == 4) tag = ex ? "R10" : "R8";
                else if (st == 0) tag = isNop ? "R2" : "R11";
                else tag = "R6";
                check(tag, errCode, expErr);
                check("R12", errPulse, expErr != 0);
                check(tag, monState, expState);
              end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule